// File: doc/BRIEF.md
# Windowed Pulse Position Searcher

This block finds where inside a symbol period a received pulse lands. It runs during a pilot stretch in which every symbol carries a pulse. The system clock runs at ten times the symbol rate, so one symbol spans ten clocks. Each clock is one window, and each window has two halves: the first half and the second half of the clock. For every window and every half, a saturating counter records how many symbols showed a hit there.

A `start` pulse clears the counters. The block then accumulates over a fixed number of symbols. A decision state machine picks the counter with the largest count. If that count reaches the threshold, the block reports the window index and the half, and raises a one-clock lock strobe. Otherwise it raises a fail flag that stays up until the next start.

The two hit flags are sampled once per clock. They carry no handshake and cannot be stalled: a sample is consumed every clock whether or not a search is running. Samples that arrive outside accumulation are discarded, so no back-pressure exists at this edge.

Top module: `pps_searcher`

## Requirements
- R1: After reset, `win_idx` is 0, `win_half` is 0, `lock_pulse` is 0 and `fail` is 0.
- R2: A `start` sampled high is followed by exactly one clear clock. Then 310 accumulate clocks (31 symbols of 10 windows) follow. The window index is 0 on the first accumulate clock and advances by one per clock, wrapping from 9 to 0.
- R3: Each accumulate clock adds 1 to the first-half counter of the current window when `hit_pos` is 1, and to the second-half counter when `hit_neg` is 1. Counters are 5 bits, stop at 31, and are cleared by every start.
- R4: The decision picks the largest of the 20 counts. On a tie, the lower window wins, and within one window the first half (`win_half`=0) wins over the second half (`win_half`=1).
- R5: When the winning count is at least 16, `lock_pulse` is high for exactly one clock. That clock comes two clocks after the last accumulate clock. `win_idx` and `win_half` hold the winner from that clock on.
- R6: When the winning count is below 16, `fail` rises in that same clock instead, with no lock strobe. `fail` stays high until the next start. A count of exactly 16 locks.
- R7: `win_idx` and `win_half` change only at a lock or at a start. A start sets them to 0 and drops `fail`.
- R8: A start sampled in any state restarts the search. This includes the decision clock, in which case that search produces neither a lock strobe nor a fail.
- R9: Hit flags seen in idle, clear, decision, locked or fail clocks have no effect on any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, ten per symbol |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) a search |
| hit_pos | input | 1 | Synchronized hit flag, first half of the clock |
| hit_neg | input | 1 | Synchronized hit flag, second half of the clock |
| win_idx | output | 4 | Locked window index, 0 to 9 |
| win_half | output | 1 | Locked half: 0 first, 1 second |
| lock_pulse | output | 1 | One-clock lock strobe |
| fail | output | 1 | Search found no window at or above threshold |

## Verification
A restart request and the decision can fall in the same clock. The bench provokes this by raising `start` in the clock right after the last accumulate sample of a search that would otherwise lock. The result is judged correct only if neither a lock strobe nor a fail flag appears, the outputs read 0, and the search that follows locks normally. A second overlap, a hit arriving in the same clock the counters are being cleared, is provoked on a pattern sitting one hit below threshold. It must still end in fail.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ACC,
    ST_DECIDE,
    ST_LOCKED,
    ST_FAIL
  } pps_state_e;
endpackage

// File: rtl/pps_window_seq.sv
// Steps the window index once per clock and the symbol count once per wrap.
module pps_window_seq #(
  parameter int NUM_WIN = 10,
  parameter int SYMBOLS = 31,
  localparam int WIN_W = $clog2(NUM_WIN),
  localparam int SYM_W = $clog2(SYMBOLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  output logic [WIN_W-1:0] win,
  output logic             last
);
  localparam logic [WIN_W-1:0] WIN_MAX = WIN_W'(NUM_WIN - 1);
  localparam logic [SYM_W-1:0] SYM_MAX = SYM_W'(SYMBOLS - 1);

  logic [SYM_W-1:0] sym;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      win <= '0;
      sym <= '0;
    end else if (run) begin
      if (win == WIN_MAX) begin
        win <= '0;
        sym <= (sym == SYM_MAX) ? '0 : sym + 1'b1;
      end else begin
        win <= win + 1'b1;
      end
    end
  end

  assign last = run && (win == WIN_MAX) && (sym == SYM_MAX);
endmodule

// File: rtl/pps_sat_ctr.sv
// Saturating up-counter with synchronous clear.
module pps_sat_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc && (cnt != {W{1'b1}})) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pps_hit_bank.sv
// Two counters per window: first-half and second-half hits.
module pps_hit_bank #(
  parameter int NUM_WIN = 10,
  parameter int CNT_W = 5,
  localparam int WIN_W = $clog2(NUM_WIN)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          en,
  input  logic [WIN_W-1:0]              win,
  input  logic                          hit_pos,
  input  logic                          hit_neg,
  output logic [NUM_WIN-1:0][CNT_W-1:0] cnt_pos,
  output logic [NUM_WIN-1:0][CNT_W-1:0] cnt_neg
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic sel;
    assign sel = en && (win == WIN_W'(g));

    pps_sat_ctr #(.W(CNT_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .inc(sel && hit_pos), .cnt(cnt_pos[g])
    );
    pps_sat_ctr #(.W(CNT_W)) u_neg (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .inc(sel && hit_neg), .cnt(cnt_neg[g])
    );
  end
endmodule

// File: rtl/pps_argmax.sv
// Largest count; scan order window 0 first-half, window 0 second-half, window 1 ...
// Strict comparison keeps the earliest entry on ties.
module pps_argmax #(
  parameter int NUM_WIN = 10,
  parameter int CNT_W = 5,
  localparam int WIN_W = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0][CNT_W-1:0] cnt_pos,
  input  logic [NUM_WIN-1:0][CNT_W-1:0] cnt_neg,
  output logic [WIN_W-1:0]              best_idx,
  output logic                          best_half,
  output logic [CNT_W-1:0]              best_cnt
);
  always_comb begin
    best_cnt  = cnt_pos[0];
    best_idx  = '0;
    best_half = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (w > 0 && cnt_pos[w] > best_cnt) begin
        best_cnt  = cnt_pos[w];
        best_idx  = WIN_W'(w);
        best_half = 1'b0;
      end
      if (cnt_neg[w] > best_cnt) begin
        best_cnt  = cnt_neg[w];
        best_idx  = WIN_W'(w);
        best_half = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pps_searcher.sv
module pps_searcher
  import pps_pkg::*;
#(
  parameter int NUM_WIN = 10,
  parameter int CNT_W = 5,
  parameter int SYMBOLS = 31,
  parameter int THRESH = 16,
  localparam int WIN_W = $clog2(NUM_WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit_pos,
  input  logic             hit_neg,
  output logic [WIN_W-1:0] win_idx,
  output logic             win_half,
  output logic             lock_pulse,
  output logic             fail
);
  localparam logic [CNT_W-1:0] THR_V = CNT_W'(THRESH);

  pps_state_e state_q, state_d;
  logic [WIN_W-1:0] seq_win;
  logic seq_last;
  logic [NUM_WIN-1:0][CNT_W-1:0] cnt_pos, cnt_neg;
  logic [WIN_W-1:0] best_idx;
  logic best_half;
  logic [CNT_W-1:0] best_cnt;
  logic pass;

  pps_window_seq #(.NUM_WIN(NUM_WIN), .SYMBOLS(SYMBOLS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q == ST_CLEAR), .run(state_q == ST_ACC),
    .win(seq_win), .last(seq_last)
  );

  pps_hit_bank #(.NUM_WIN(NUM_WIN), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q == ST_CLEAR), .en(state_q == ST_ACC),
    .win(seq_win), .hit_pos(hit_pos), .hit_neg(hit_neg),
    .cnt_pos(cnt_pos), .cnt_neg(cnt_neg)
  );

  pps_argmax #(.NUM_WIN(NUM_WIN), .CNT_W(CNT_W)) u_max (
    .cnt_pos(cnt_pos), .cnt_neg(cnt_neg),
    .best_idx(best_idx), .best_half(best_half), .best_cnt(best_cnt)
  );

  assign pass = (best_cnt >= THR_V);

  always_comb begin
    state_d = state_q;
    if (start) state_d = ST_CLEAR;
    else begin
      case (state_q)
        ST_CLEAR:  state_d = ST_ACC;
        ST_ACC:    if (seq_last) state_d = ST_DECIDE;
        ST_DECIDE: state_d = pass ? ST_LOCKED : ST_FAIL;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      win_idx    <= '0;
      win_half   <= 1'b0;
      lock_pulse <= 1'b0;
      fail       <= 1'b0;
    end else begin
      state_q    <= state_d;
      lock_pulse <= 1'b0;
      if (start) begin
        win_idx  <= '0;
        win_half <= 1'b0;
        fail     <= 1'b0;
      end else if (state_q == ST_DECIDE) begin
        if (pass) begin
          win_idx    <= best_idx;
          win_half   <= best_half;
          lock_pulse <= 1'b1;
        end else begin
          fail <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pps_searcher_chk.sv
module pps_searcher_chk
  import pps_pkg::*;
#(
  parameter int NUM_WIN = 10,
  localparam int WIN_W = $clog2(NUM_WIN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIN_W-1:0] win_idx,
  input logic             win_half,
  input logic             lock_pulse,
  input logic             fail,
  input pps_state_e       state_q,
  input logic [WIN_W-1:0] seq_win
);
  // R2
  clear_then_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLEAR && !start) |=> (state_q == ST_ACC && seq_win == '0));

  // R2
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_win < WIN_W'(NUM_WIN));

  // R5
  lock_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse |=> !lock_pulse);

  // R6
  lock_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_pulse && fail));

  // R6
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  // R7
  result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(win_idx) || !$stable(win_half)) |-> ($past(start) || lock_pulse));

  // R8
  start_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!lock_pulse && !fail && win_idx == '0 && !win_half));
endmodule

bind pps_searcher pps_searcher_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .win_idx(win_idx),
  .win_half(win_half), .lock_pulse(lock_pulse), .fail(fail),
  .state_q(state_q), .seq_win(seq_win)
);

// File: tb/pps_searcher_tb.sv
module pps_searcher_tb;
  localparam int NW = 10;
  localparam int NSYM = 31;
  localparam int NS = NW * NSYM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic hit_pos = 1'b0;
  logic hit_neg = 1'b0;
  logic [3:0] win_idx;
  logic win_half, lock_pulse, fail;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  logic pat_p [NS];
  logic pat_n [NS];

  always #5 clk = ~clk;

  pps_searcher u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hit_pos(hit_pos), .hit_neg(hit_neg),
    .win_idx(win_idx), .win_half(win_half), .lock_pulse(lock_pulse), .fail(fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_pat();
    for (int k = 0; k < NS; k++) begin
      pat_p[k] = 1'b0;
      pat_n[k] = 1'b0;
    end
  endtask

  // Pulse at window w, half h, in the first nsym symbols.
  task automatic add_pulse(input int w, input int h, input int nsym);
    for (int s = 0; s < nsym; s++) begin
      if (h == 0) pat_p[s * NW + w] = 1'b1;
      else        pat_n[s * NW + w] = 1'b1;
    end
  endtask

  // Runs one search; stray=1 drives hits in the start and clear clocks (R9);
  // abort=1 raises start in the decision clock (R8).
  task automatic search(input string tag, input bit stray, input bit abort);
    int cp [NW];
    int cn [NW];
    int bc, bi, bh;
    for (int w = 0; w < NW; w++) begin cp[w] = 0; cn[w] = 0; end
    for (int k = 0; k < NS; k++) begin
      if (pat_p[k] && cp[k % NW] < 31) cp[k % NW]++;
      if (pat_n[k] && cn[k % NW] < 31) cn[k % NW]++;
    end
    bc = cp[0]; bi = 0; bh = 0;
    for (int w = 0; w < NW; w++) begin
      if (w > 0 && cp[w] > bc) begin bc = cp[w]; bi = w; bh = 0; end
      if (cn[w] > bc) begin bc = cn[w]; bi = w; bh = 1; end
    end

    @(negedge clk);
    start = 1'b1; hit_pos = stray; hit_neg = stray;
    @(negedge clk);
    start = 1'b0;
    // R7: start clears result and fail
    chk(win_idx == 0 && !win_half && !fail, {tag, " R7 start clears"},
        {win_idx, win_half, fail}, 0);
    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      hit_pos = pat_p[k]; hit_neg = pat_n[k];
    end
    @(negedge clk);
    hit_pos = stray; hit_neg = stray;
    // R5: nothing yet in the decision clock
    chk(!lock_pulse && !fail, {tag, " R5 decide clock quiet"}, {lock_pulse, fail}, 0);
    if (abort) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R8: restart in the decision clock suppresses its outcome
      chk(!lock_pulse && !fail && win_idx == 0, {tag, " R8 abort"},
          {lock_pulse, fail, win_idx}, 0);
      @(negedge clk);
      chk(!lock_pulse && !fail, {tag, " R8 abort later"}, {lock_pulse, fail}, 0);
      return;
    end
    @(negedge clk);
    if (bc >= 16) begin
      // R4 R5
      chk(lock_pulse && !fail, {tag, " R5 lock strobe"}, {lock_pulse, fail}, 2);
      chk(win_idx == bi && win_half == bh, {tag, " R4 winner"},
          win_idx * 2 + win_half, bi * 2 + bh);
    end else begin
      // R6
      chk(fail && !lock_pulse, {tag, " R6 fail"}, {lock_pulse, fail}, 1);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      // R5 R6 R7: strobe ends, fail and result hold
      chk(!lock_pulse && fail == (bc < 16), {tag, " R5/R6 after"}, {lock_pulse, fail},
          (bc < 16) ? 1 : 0);
      if (bc >= 16)
        chk(win_idx == bi && win_half == bh, {tag, " R7 hold"},
            win_idx * 2 + win_half, bi * 2 + bh);
    end
    hit_pos = 1'b0; hit_neg = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(win_idx == 0 && !win_half && !lock_pulse && !fail, "R1 reset",
        {win_idx, win_half, lock_pulse, fail}, 0);

    // R2 R3 R4: every window and half, a full-strength pilot
    for (int w = 0; w < NW; w++)
      for (int h = 0; h < 2; h++) begin
        clear_pat();
        add_pulse(w, h, NSYM);
        search($sformatf("sweep w%0d h%0d R2 R3", w, h), 1'b0, 1'b0);
      end

    // R4 ties
    clear_pat(); add_pulse(7, 0, NSYM); add_pulse(2, 1, NSYM);
    search("tie across windows R4", 1'b0, 1'b0);
    clear_pat(); add_pulse(4, 1, NSYM); add_pulse(4, 0, NSYM);
    search("tie within window R4", 1'b0, 1'b0);
    clear_pat(); add_pulse(5, 1, 20); add_pulse(9, 0, 20); add_pulse(1, 1, 18);
    search("partial tie R4", 1'b0, 1'b0);

    // R6 threshold boundary
    clear_pat(); add_pulse(6, 1, 16);
    search("count 16 R6", 1'b0, 1'b0);
    clear_pat(); add_pulse(6, 1, 15);
    search("count 15 R6", 1'b0, 1'b0);

    // R9: stray hits outside accumulation would lift 15 to threshold
    clear_pat(); add_pulse(0, 0, 15);
    search("stray hits R9", 1'b1, 1'b0);

    // R3: noisy background plus a true pulse
    clear_pat();
    for (int k = 0; k < NS; k++) begin
      pat_p[k] = ((k * 7 + 3) % 5 == 0);
      pat_n[k] = ((k * 11 + 1) % 6 == 0);
    end
    add_pulse(8, 1, 25);
    search("noisy R3", 1'b0, 1'b0);

    // R8: start in the decision clock, then a normal search
    clear_pat(); add_pulse(3, 0, NSYM);
    search("abort R8", 1'b0, 1'b1);
    clear_pat(); add_pulse(2, 0, NSYM);
    search("after abort R8", 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule